// File: doc/BRIEF.md
# Serial Converter Host Link Controller

This block is the host end of a synchronous serial link to a data converter. The link has a serial clock driven by the host, two active-low frame selects (one that frames writes, one that frames reads), a host-to-converter data line and a converter-to-host data line. On a command the block sends a 6-bit control word to the converter, or it fetches a 16-bit conversion result. A read can also be started by a falling edge on the converter's end-of-conversion line.

A control word goes out left-justified in a single 8-clock byte. A result is fetched as two bytes, with the read frame select held low across both. Both directions move the most significant bit first. The serial clock idles high. Data is launched on its rising edge and sampled on its falling edge. An optional reversal mode serves hosts that work least-significant-bit first: the command word is taken in reversed order, and each result byte is returned bit-reversed. The clock rate comes from a programmable half-period given in system clocks.

The result leaves on a valid/ready stream. `rd_valid` rises together with the result and stays high, with `rd_data` unchanged, until `rd_ready` is seen high on a clock edge. While a result waits, the block counts as busy and accepts no new command. The stream cannot lose or overwrite a result.

Top module: `sadc_link_ctrl`

## Requirements
- R1: A write holds `tfs_n` low and a read holds `rfs_n` low. Only one of the two frame selects is ever low at a time.
- R2: A write frame has exactly 8 falling `sclk` edges. The byte sent on `dout` is the 6-bit word followed by two 0 bits, most significant bit first. `tfs_n` returns high after the eighth bit.
- R3: A read frame keeps `rfs_n` low without a break across 16 falling `sclk` edges. `rd_data` holds the 16 sampled bits in arrival order, so the first bit received lands in `rd_data[15]`.
- R4: H is `half_div` captured when a command is accepted, with 0 read as 1. A frame select goes low H clocks before the first falling edge of `sclk`. Each half of an `sclk` period then lasts H clocks. `sclk` is high whenever no frame select is low. `dout` changes only when `sclk` rises, and `din` is sampled when `sclk` falls.
- R5: With `rev_en` high, `cmd_word[0]` is the first bit sent, and each result byte is bit-reversed in place (bit 15 swaps with bit 8, bit 7 swaps with bit 0, and so on).
- R6: A falling edge on `eoc_n` starts a read only when `auto_rd_en` is high and the block is not busy. Otherwise the edge is dropped.
- R7: `busy` goes high on the clock edge after a command is accepted. It stays high until 2H clocks after the frame select rises, and for as long as a result is pending. Commands that arrive while `busy` is high have no effect.
- R8: `rd_valid` and `rd_data` hold steady until a clock edge that sees `rd_ready` high. When `rd_ready` is already high, `rd_valid` lasts one cycle.
- R9: When commands arrive together, a write beats a read, and a read command beats an end-of-conversion edge.
- R10: After reset both frame selects and `sclk` are high, and `dout`, `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | 8 | Half-period of `sclk` in system clocks; 0 is treated as 1 |
| rev_en | input | 1 | Reverse-bit-order host mode |
| auto_rd_en | input | 1 | Allows an `eoc_n` falling edge to start a read |
| cmd_wr | input | 1 | Request to write the control word |
| cmd_word | input | 6 | Control word to send |
| cmd_rd | input | 1 | Request to read a result |
| eoc_n | input | 1 | End-of-conversion line from the converter, active low |
| busy | output | 1 | High while a transfer, guard time or pending result blocks commands |
| rd_valid | output | 1 | Result stream valid |
| rd_ready | input | 1 | Result stream ready |
| rd_data | output | 16 | Result, first byte in the upper half |
| sclk | output | 1 | Serial clock, idles high |
| tfs_n | output | 1 | Write frame select, active low |
| rfs_n | output | 1 | Read frame select, active low |
| dout | output | 1 | Serial data to the converter |
| din | input | 1 | Serial data from the converter |

## Verification
The hardest cases to reach from the ports are an end-of-conversion edge arriving while the block is busy, and back-pressure on the result stream. The stimulus drops `eoc_n` in the middle of a write frame with automatic reads enabled. It then checks that no read frame follows the write. It also holds `rd_ready` low after a read so that the pending result blocks a following command. A cycle-accurate model plays the converter on `din` and predicts every output on every clock, across several half-period settings that include the zero case.

// File: rtl/sadc_link_pkg.sv
`timescale 1ns/1ps
package sadc_link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_GUARD = 2'd2
  } link_state_e;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } link_op_e;
endpackage

// File: rtl/sadc_sclk_gen.sv
`timescale 1ns/1ps
// Half-period timer: one tick every half_len clocks while running.
module sadc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (tick)             cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_bitrev.sv
`timescale 1ns/1ps
module sadc_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_in,
  output logic [W-1:0] bits_out
);
  for (genvar i = 0; i < W; i++) begin : g_swap
    assign bits_out[i] = bits_in[W-1-i];
  end
endmodule

// File: rtl/sadc_shifter.sv
`timescale 1ns/1ps
// Outgoing byte register and incoming result register.
module sadc_shifter #(
  parameter int BYTE_W = 8,
  parameter int RX_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              launch,
  input  logic              capture,
  input  logic              din,
  output logic              dout,
  output logic [RX_W-1:0]   rx_word
);
  logic [BYTE_W-1:0] tx_sr;

  assign dout = tx_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sr <= '0;
    else if (load)    tx_sr <= load_byte;
    else if (launch)  tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_word <= '0;
    else if (load)     rx_word <= '0;
    else if (capture)  rx_word <= {rx_word[RX_W-2:0], din};
  end
endmodule

// File: rtl/sadc_link_ctrl.sv
`timescale 1ns/1ps
module sadc_link_ctrl
  import sadc_link_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CMD_W    = 6,
  parameter int BYTE_W   = 8,
  parameter int RD_BYTES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIV_W-1:0]             half_div,
  input  logic                         rev_en,
  input  logic                         auto_rd_en,
  input  logic                         cmd_wr,
  input  logic [CMD_W-1:0]             cmd_word,
  input  logic                         cmd_rd,
  input  logic                         eoc_n,
  output logic                         busy,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [BYTE_W*RD_BYTES-1:0]   rd_data,
  output logic                         sclk,
  output logic                         tfs_n,
  output logic                         rfs_n,
  output logic                         dout,
  input  logic                         din
);
  localparam int RX_W   = BYTE_W * RD_BYTES;
  localparam int PAD    = BYTE_W - CMD_W;
  localparam int HALF_W = $clog2(2 * RX_W + 1);
  localparam logic [HALF_W-1:0] WR_LAST = HALF_W'(2 * BYTE_W);
  localparam logic [HALF_W-1:0] RD_LAST = HALF_W'(2 * RX_W);

  link_state_e        state;
  link_op_e           op_q;
  logic [HALF_W-1:0]  hcnt;
  logic [DIV_W-1:0]   half_q;
  logic               eoc_q;

  logic               eoc_fall, idle_ok, go_wr, go_rd, start;
  logic               tick, in_xfer, launch, capture, at_last;
  logic [HALF_W-1:0]  last_half;
  logic [CMD_W-1:0]   cmd_rev, cmd_sel;
  logic [BYTE_W-1:0]  tx_byte;
  logic [RX_W-1:0]    rx_word, rx_rev;

  // Command acceptance with write > read > end-of-conversion priority.
  assign eoc_fall = eoc_q & ~eoc_n;
  assign idle_ok  = (state == ST_IDLE) && !rd_valid;
  assign go_wr    = idle_ok && cmd_wr;
  assign go_rd    = idle_ok && !cmd_wr && (cmd_rd || (auto_rd_en && eoc_fall));
  assign start    = go_wr || go_rd;

  sadc_bitrev #(.W(CMD_W)) u_cmd_rev (.bits_in(cmd_word), .bits_out(cmd_rev));
  assign cmd_sel = rev_en ? cmd_rev : cmd_word;
  assign tx_byte = go_wr ? (BYTE_W'(cmd_sel) << PAD) : '0;

  sadc_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state != ST_IDLE),
    .restart  (start),
    .half_len (half_q),
    .tick     (tick)
  );

  assign in_xfer   = (state == ST_XFER);
  assign last_half = (op_q == OP_READ) ? RD_LAST : WR_LAST;
  assign at_last   = (hcnt == last_half);
  assign launch    = tick && in_xfer && hcnt[0];
  assign capture   = tick && in_xfer && !hcnt[0] && !at_last;

  sadc_shifter #(.BYTE_W(BYTE_W), .RX_W(RX_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_byte (tx_byte),
    .launch    (launch),
    .capture   (capture),
    .din       (din),
    .dout      (dout),
    .rx_word   (rx_word)
  );

  for (genvar g = 0; g < RD_BYTES; g++) begin : g_byte_rev
    sadc_bitrev #(.W(BYTE_W)) u_rev (
      .bits_in  (rx_word[g*BYTE_W +: BYTE_W]),
      .bits_out (rx_rev[g*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoc_q <= 1'b1;
    else        eoc_q <= eoc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_WRITE;
      hcnt   <= '0;
      half_q <= DIV_W'(1);
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_XFER;
          op_q   <= go_rd ? OP_READ : OP_WRITE;
          hcnt   <= '0;
          half_q <= (half_div == '0) ? DIV_W'(1) : half_div;
        end
        ST_XFER: if (tick) begin
          if (at_last) begin
            state <= ST_GUARD;
            hcnt  <= '0;
          end else begin
            hcnt  <= hcnt + 1'b1;
          end
        end
        ST_GUARD: if (tick) begin
          if (hcnt == HALF_W'(1)) begin
            state <= ST_IDLE;
            hcnt  <= '0;
          end else begin
            hcnt  <= hcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Result stream register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (tick && in_xfer && at_last && (op_q == OP_READ)) begin
      rd_valid <= 1'b1;
      rd_data  <= rev_en ? rx_rev : rx_word;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign sclk  = !(in_xfer && hcnt[0]);
  assign tfs_n = !(in_xfer && (op_q == OP_WRITE));
  assign rfs_n = !(in_xfer && (op_q == OP_READ));
  assign busy  = (state != ST_IDLE) || rd_valid;
endmodule

// File: rtl/sadc_link_checker.sv
`timescale 1ns/1ps
module sadc_link_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          sclk,
  input logic          tfs_n,
  input logic          rfs_n
);
  p_one_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tfs_n && !rfs_n));

  p_sclk_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tfs_n && rfs_n) |-> sclk);

  p_frame_implies_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tfs_n || !rfs_n) |-> busy);

  p_start_only_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tfs_n) || $fell(rfs_n)) |-> !$past(busy));

  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_result_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rfs_n && $past(!rfs_n)));
endmodule

bind sadc_link_ctrl sadc_link_checker #(.DW(BYTE_W * RD_BYTES)) u_link_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .sclk     (sclk),
  .tfs_n    (tfs_n),
  .rfs_n    (rfs_n)
);

// File: tb/sadc_link_ctrl_bench.sv
`timescale 1ns/1ps
module sadc_link_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic        rev_en = 1'b0, auto_rd_en = 1'b0;
  logic        cmd_wr = 1'b0, cmd_rd = 1'b0;
  logic [5:0]  cmd_word = '0;
  logic        eoc_n = 1'b1;
  logic        rd_ready = 1'b1;
  logic        din = 1'b0;
  logic        busy, rd_valid, sclk, tfs_n, rfs_n, dout;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  sadc_link_ctrl u_sadc_link_ctrl (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .rev_en(rev_en),
    .auto_rd_en(auto_rd_en), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_rd(cmd_rd), .eoc_n(eoc_n), .busy(busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .sclk(sclk), .tfs_n(tfs_n),
    .rfs_n(rfs_n), .dout(dout), .din(din)
  );

  int checks = 0, fails = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [5:0] rev6(logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  // Behavioural reference: time since acceptance drives everything.
  bit          m_act, m_rd, m_valid, m_prev_eoc;
  int          m_t, m_h;
  logic [7:0]  m_tx;
  logic [15:0] m_data;
  logic [15:0] conv_word = 16'hA53C;

  function automatic int frame_len();
    return m_h * (1 + 16 * (m_rd ? 2 : 1));
  endfunction

  always @(posedge clk) begin
    bit pre_valid, fall;
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_valid = 0; m_prev_eoc = 1;
      m_t = 0; m_h = 1; m_tx = '0; m_data = '0;
    end else begin
      pre_valid = m_valid;
      fall = m_prev_eoc && !eoc_n;
      if (m_valid && rd_ready) m_valid = 0;
      if (m_act) begin
        m_t++;
        if (m_rd && m_t == frame_len()) begin
          m_valid = 1;
          m_data = rev_en ? {rev8(conv_word[15:8]), rev8(conv_word[7:0])} : conv_word;
        end
        if (m_t == frame_len() + 2 * m_h) m_act = 0;
      end else if (!pre_valid && (cmd_wr || cmd_rd || (auto_rd_en && fall))) begin
        m_act = 1;
        m_t   = 0;
        m_rd  = !cmd_wr;
        m_h   = (half_div == 0) ? 1 : int'(half_div);
        m_tx  = cmd_wr ? {(rev_en ? rev6(cmd_word) : cmd_word), 2'b00} : 8'h00;
      end
      m_prev_eoc = eoc_n;
    end
  end

  // Converter model: next bit appears after each rising sclk.
  always @(negedge clk) begin
    int idx;
    idx = m_t / (2 * m_h);
    if (idx > 15) idx = 15;
    din <= (m_act && m_rd && m_t < frame_len()) ? conv_word[15-idx] : 1'b0;
  end

  // Per-cycle comparison against the model.
  bit cmp_en = 0;
  always @(negedge clk) begin
    bit fr;
    int idx;
    logic e_dout;
    if (cmp_en) begin
      fr  = m_act && (m_t < frame_len());
      idx = m_t / (2 * m_h);
      e_dout = (fr && !m_rd && idx < 8) ? m_tx[7-idx] : 1'b0;
      chk("R1", "tfs_n", tfs_n, !(fr && !m_rd));
      chk("R1", "rfs_n", rfs_n, !(fr && m_rd));
      chk("R4", "sclk", sclk, !(fr && ((m_t / m_h) % 2 == 1)));
      chk("R2", "dout", dout, e_dout);
      chk("R7", "busy", busy, m_act || m_valid);
      chk("R8", "rd_valid", rd_valid, m_valid);
      if (m_valid) chk("R3/R5", "rd_data", rd_data, m_data);
    end
  end

  // Falling-edge count per frame.
  logic p_sclk = 1, p_tfs = 1, p_rfs = 1;
  int   falls = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      if ((p_tfs && !tfs_n) || (p_rfs && !rfs_n)) falls = 0;
      else if (p_sclk && !sclk) falls++;
      if (!p_tfs && tfs_n) chk("R2", "write falls", falls, 8);
      if (!p_rfs && rfs_n) chk("R3", "read falls", falls, 16);
    end
    p_sclk = sclk; p_tfs = tfs_n; p_rfs = rfs_n;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_free();
    while (m_act || m_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_wr(logic [5:0] w, logic [7:0] h);
    @(negedge clk); half_div = h; cmd_word = w; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic send_rd(logic [7:0] h);
    @(negedge clk); half_div = h; cmd_rd = 1;
    @(negedge clk); cmd_rd = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    @(negedge clk); rst_n = 1; cmp_en = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "tfs_n", tfs_n, 1); chk("R10", "rfs_n", rfs_n, 1);
    chk("R10", "sclk", sclk, 1);   chk("R10", "dout", dout, 0);
    chk("R10", "busy", busy, 0);   chk("R10", "rd_valid", rd_valid, 0);

    // R2 plain write, fastest clock
    send_wr(6'b101101, 8'd1); wait_free();
    // R5 reversed write, slower clock
    rev_en = 1; send_wr(6'b110010, 8'd3); wait_free(); rev_en = 0;
    // R3 read, then R5 reversed read
    conv_word = 16'hA53C; send_rd(8'd2); wait_free();
    rev_en = 1; conv_word = 16'h1E87; send_rd(8'd1); wait_free(); rev_en = 0;
    // R4 half_div of zero acts as one
    conv_word = 16'h6D92; send_rd(8'd0); wait_free();

    // R8 back-pressure, R7 command ignored while result pending
    rd_ready = 0; conv_word = 16'hC3F0; send_rd(8'd1);
    while (!m_valid) @(negedge clk);
    cyc(6);
    send_wr(6'b111111, 8'd1); cyc(3);
    chk("R8", "held valid", rd_valid, 1);
    chk("R7", "tfs_n while pending", tfs_n, 1);
    rd_ready = 1; wait_free();

    // R9 write beats read in the same cycle
    @(negedge clk); half_div = 8'd2; cmd_word = 6'b000111; cmd_wr = 1; cmd_rd = 1;
    @(negedge clk); cmd_wr = 0; cmd_rd = 0;
    chk("R9", "tfs_n", tfs_n, 0); chk("R9", "rfs_n", rfs_n, 1);
    wait_free();

    // R6 edge ignored when automatic reads are off
    auto_rd_en = 0; @(negedge clk); eoc_n = 0; cyc(4); eoc_n = 1; cyc(2);
    chk("R6", "rfs_n auto off", rfs_n, 1); chk("R6", "busy auto off", busy, 0);
    // R6 edge starts read when enabled
    auto_rd_en = 1; conv_word = 16'h0FF1; half_div = 8'd2;
    @(negedge clk); eoc_n = 0; @(negedge clk);
    chk("R6", "rfs_n auto on", rfs_n, 0);
    eoc_n = 1; wait_free();
    // R6 edge during a write is dropped
    send_wr(6'b010101, 8'd2); cyc(5); eoc_n = 0; cyc(3); eoc_n = 1;
    wait_free(); cyc(2);
    chk("R6", "no read after busy edge", rfs_n, 1);
    chk("R6", "busy after dropped edge", busy, 0);
    // R9 read command beats simultaneous edge (one read only)
    @(negedge clk); half_div = 8'd1; cmd_rd = 1; eoc_n = 0;
    @(negedge clk); cmd_rd = 0; eoc_n = 1;
    wait_free();
    auto_rd_en = 0;
    cyc(4);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule